// File: doc/BRIEF.md
# Dual-Mode General-Purpose Timer

A 32-bit timer peripheral on a simple single-cycle register bus. An up-counter runs every clock cycle, or at a lower rate set by a power-of-two prescaler. When it passes its all-ones value it raises an overflow event. It then either reloads from a load register or wraps to zero and stops itself. A write to the trigger register also copies the load value into the counter.

The timer can raise three events: compare-match, overflow and input capture. Each event sets a sticky status flag. Software clears a flag by writing one to its bit. An enable mask decides which flags drive the interrupt line. The capture input is watched for a chosen edge, and on that edge the current count is copied into the capture register.

The PWM pin sits at a programmable idle level. Overflow, or overflow and match, either toggles it or produces a one-cycle pulse on it. The pin can also be forced to the idle level as a plain output. Other features:
- A soft reset clears the block over a few cycles and reports when it has finished.
- A write-pending register shows, for two cycles after each write, which registers were written.

Top module: `gp_timer`

## Requirements
- R1: After reset:
  - the identification register (0x00) reads 0x00000021;
  - control (0x24), counter (0x28) and interrupt status (0x18) read 0;
  - bit 0 of system status (0x14) reads 1;
  - the interrupt output is low.
- R2: While control bit 0 (run) is 1 and the prescaler is off, the counter rises by one each cycle. While run is 0 it holds its value.
- R3: With control bit 5 (prescaler enable) set and bits 4:2 holding N, the counter advances once every 2^(N+1) cycles.
- R4: When the counter advances from 0xFFFFFFFF, status bit 1 (overflow) is set.
  - If control bit 1 (auto-reload) is 1, the counter takes the load register (0x2C).
  - Otherwise it becomes 0 and run clears.
- R5: A write of any value to the trigger register (0x30) copies the load register into the counter.
- R6: With control bit 6 (compare enable) set, status bit 0 (match) is set when the counter advances to the value in the match register (0x38).
- R7: Control bits 9:8 select the capture edge: 01 rising, 10 falling, 11 both, 00 off. On a selected edge of the capture input, the capture register (0x3C) takes the counter value and status bit 2 is set.
- R8: Status flags stay set until a write to 0x18 with a one in their bit position; zeros in that write leave flags alone. The interrupt output is high when any status bit and the same bit of the enable register (0x1C) are both 1.
- R9: PWM behaviour is set by three control fields:
  - bit 7 is the idle level of the PWM pin;
  - bits 11:10 pick the trigger: 00 none, 01 overflow, 10 overflow or match;
  - bit 12 picks the response: 1 toggles the pin on each trigger, 0 drives it to the opposite of idle for one cycle.
- R10: With control bit 14 set, the PWM pin holds the idle level whatever the trigger events.
- R11: A write to the interface control register (0x40) with bit 1 set (e.g. 0x06) starts a soft reset. During the soft reset:
  - system status bit 0 reads 0 for 4 cycles;
  - the registers return to their reset values;
  - register writes are ignored.
  Afterwards bit 0 reads 1 again.
- R12: After a write to a register, its bit in the write-pending register (0x34) reads 1 for two cycles. The bits are:
  - bit 0 control;
  - bit 1 counter;
  - bit 2 load;
  - bit 3 trigger;
  - bit 4 match.
- R13: Ready is high in the same cycle as a request. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid with rsp_ready |
| rsp_ready | output | 1 | Request accepted this cycle |
| cap_in | input | 1 | Capture input |
| pwm_out | output | 1 | PWM / general-purpose output pin |
| irq | output | 1 | Interrupt request |

## Verification
The counter is run in several ways:
- freely;
- prescaled at N = 0, 1, 2 and 7, which separates the divide ratio from an off-by-one in the prescale terminal count;
- across the all-ones boundary with and without auto-reload, which separates reload from one-shot stop.

Capture is driven with a high pulse under each of the four edge codes. Rising-only and falling-only then give different captured counts, and code 00 leaves the register unchanged. PWM runs in toggle and pulse mode under both trigger choices, so a missing match term or a swapped mode bit shows on the pin within one overflow period.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;

   // Register byte offsets: software decodes these.
   localparam int OFS_ID    = 'h00;
   localparam int OFS_IFCFG = 'h10;
   localparam int OFS_SYSST = 'h14;
   localparam int OFS_ISTAT = 'h18;
   localparam int OFS_IEN   = 'h1C;
   localparam int OFS_WEN   = 'h20;
   localparam int OFS_CTRL  = 'h24;
   localparam int OFS_CNT   = 'h28;
   localparam int OFS_LOAD  = 'h2C;
   localparam int OFS_TRIG  = 'h30;
   localparam int OFS_WPEND = 'h34;
   localparam int OFS_MATCH = 'h38;
   localparam int OFS_CAPT  = 'h3C;
   localparam int OFS_IFCTL = 'h40;

   // Control bit positions.
   localparam int CB_RUN    = 0;
   localparam int CB_AUTO   = 1;
   localparam int CB_PRE_LO = 2;
   localparam int CB_PEN    = 5;
   localparam int CB_CMP    = 6;
   localparam int CB_IDLE   = 7;
   localparam int CB_EDGE   = 8;
   localparam int CB_PTRIG  = 10;
   localparam int CB_TOGGLE = 12;
   localparam int CB_GPO    = 14;

   // Status flag positions.
   localparam int SB_MATCH = 0;
   localparam int SB_OVF   = 1;
   localparam int SB_CAP   = 2;
   localparam int NFLAG    = 3;

   // Write-pending slots.
   localparam int NPEND = 5;

   typedef enum logic [1:0] {
      PT_NONE      = 2'b00,
      PT_OVF       = 2'b01,
      PT_OVF_MATCH = 2'b10,
      PT_RSVD      = 2'b11
   } pwm_trig_e;

endpackage

// File: rtl/gp_timer_prescale.sv
module gp_timer_prescale #(
   parameter int PRE_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             enable,
   input  logic [PRE_W-1:0] sel,
   output logic             tick
);
   localparam int CW = 1 << PRE_W;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;
   logic          wrap;

   if (PRE_W < 1 || PRE_W > 3) begin : g_bad_prew
      $error("gp_timer_prescale: PRE_W must lie in 1..3");
   end

   // 2^(sel+1)-1; the top setting wraps the shift to zero and yields all ones.
   assign limit = ({{(CW-1){1'b0}}, 1'b1} << ({1'b0, sel} + 1'b1)) - 1'b1;
   assign wrap  = (cnt_q == limit);
   assign tick  = run & (~enable | wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (!run || !enable || wrap) cnt_q <= '0;
      else                            cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/gp_timer_edge.sv
module gp_timer_edge (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   input  logic [1:0] mode,
   output logic       hit
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= din;
   end

   assign hit = (mode[0] & din & ~prev_q) | (mode[1] & ~din & prev_q);
endmodule

// File: rtl/gp_timer_pwm.sv
module gp_timer_pwm
   import gp_timer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idle_lvl,
   input  logic       toggle,
   input  logic       gpo,
   input  logic [1:0] trig,
   input  logic       ovf_evt,
   input  logic       match_evt,
   output logic       pwm
);
   logic fire;
   logic state_q;
   logic pulse_q;

   assign fire = ((trig == PT_OVF) & ovf_evt) |
                 ((trig == PT_OVF_MATCH) & (ovf_evt | match_evt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= fire;
         if (trig == PT_NONE) state_q <= 1'b0;
         else if (fire)       state_q <= ~state_q;
      end
   end

   assign pwm = gpo ? idle_lvl : idle_lvl ^ (toggle ? state_q : pulse_q);
endmodule

// File: rtl/gp_timer.sv
module gp_timer
   import gp_timer_pkg::*;
#(
   parameter int          DW          = 32,
   parameter int          AW          = 8,
   parameter int          PRE_W       = 3,
   parameter int          RST_CYCLES  = 4,
   parameter int          PEND_CYCLES = 2,
   parameter logic [31:0] ID_VALUE    = 32'h0000_0021
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic [DW-1:0] rsp_rdata,
   output logic          rsp_ready,
   input  logic          cap_in,
   output logic          pwm_out,
   output logic          irq
);
   localparam int            RCW       = $clog2(RST_CYCLES + 1);
   localparam int            PCW       = $clog2(PEND_CYCLES + 1);
   localparam logic [DW-1:0] CTRL_MASK = DW'(32'h0000_7FFF);

   if (DW < 16 || DW > 64) begin : g_bad_dw
      $error("gp_timer: DW must lie in 16..64");
   end
   if (AW < 7 || AW > 16) begin : g_bad_aw
      $error("gp_timer: AW must lie in 7..16");
   end
   if (RST_CYCLES < 1 || PEND_CYCLES < 1) begin : g_bad_cyc
      $error("gp_timer: RST_CYCLES and PEND_CYCLES must be positive");
   end

   logic [DW-1:0]    ctrl_q, cnt_q, load_q, match_q, capt_q, ifcfg_q;
   logic [NFLAG-1:0] stat_q, ien_q, wen_q;
   logic [RCW-1:0]   srst_q;
   logic [NPEND-1:0] pend_hit, pend_vec;

   logic busy, wr;
   logic wr_ctrl, wr_cnt, wr_load, wr_trig, wr_match, wr_stat;
   logic wr_ien, wr_wen, wr_ifcfg, wr_ifctl;
   logic run_en, pre_en, auto_en, cmp_en;
   logic tick, at_max, ovf_evt, match_evt, cap_evt;
   logic [DW-1:0]    adv;
   logic [NFLAG-1:0] clr_mask, evt_vec;

   function automatic logic at(input int ofs);
      return req_addr == AW'(ofs);
   endfunction

   // ---------------- bus decode ----------------
   assign busy      = (srst_q != '0);
   assign wr        = req_valid & req_write & ~busy;
   assign wr_ctrl   = wr & at(OFS_CTRL);
   assign wr_cnt    = wr & at(OFS_CNT);
   assign wr_load   = wr & at(OFS_LOAD);
   assign wr_trig   = wr & at(OFS_TRIG);
   assign wr_match  = wr & at(OFS_MATCH);
   assign wr_stat   = wr & at(OFS_ISTAT);
   assign wr_ien    = wr & at(OFS_IEN);
   assign wr_wen    = wr & at(OFS_WEN);
   assign wr_ifcfg  = wr & at(OFS_IFCFG);
   assign wr_ifctl  = wr & at(OFS_IFCTL);
   assign rsp_ready = req_valid;

   // ---------------- counting ----------------
   assign run_en  = ctrl_q[CB_RUN];
   assign pre_en  = ctrl_q[CB_PEN];
   assign auto_en = ctrl_q[CB_AUTO];
   assign cmp_en  = ctrl_q[CB_CMP];

   gp_timer_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_en & ~busy),
      .enable (pre_en),
      .sel    (ctrl_q[CB_PRE_LO +: PRE_W]),
      .tick   (tick)
   );

   assign at_max    = &cnt_q;
   assign adv       = at_max ? (auto_en ? load_q : '0) : cnt_q + 1'b1;
   assign ovf_evt   = tick & at_max;
   assign match_evt = tick & cmp_en & (adv == match_q);

   gp_timer_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cap_in),
      .mode  (ctrl_q[CB_EDGE +: 2]),
      .hit   (cap_evt)
   );

   gp_timer_pwm u_pwm (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle_lvl  (ctrl_q[CB_IDLE]),
      .toggle    (ctrl_q[CB_TOGGLE]),
      .gpo       (ctrl_q[CB_GPO]),
      .trig      (ctrl_q[CB_PTRIG +: 2]),
      .ovf_evt   (ovf_evt),
      .match_evt (match_evt),
      .pwm       (pwm_out)
   );

   // ---------------- flags ----------------
   always_comb begin
      evt_vec           = '0;
      evt_vec[SB_MATCH] = match_evt;
      evt_vec[SB_OVF]   = ovf_evt;
      evt_vec[SB_CAP]   = cap_evt;
   end
   assign clr_mask = wr_stat ? req_wdata[NFLAG-1:0] : '0;
   assign irq      = |(stat_q & ien_q);

   // ---------------- register state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0; cnt_q <= '0; load_q <= '0; match_q <= '0; capt_q <= '0;
         ifcfg_q <= '0; stat_q <= '0; ien_q <= '0; wen_q <= '0;
      end else if (busy) begin
         ctrl_q <= '0; cnt_q <= '0; load_q <= '0; match_q <= '0; capt_q <= '0;
         ifcfg_q <= '0; stat_q <= '0; ien_q <= '0; wen_q <= '0;
      end else begin
         if (wr_ctrl)                  ctrl_q <= req_wdata & CTRL_MASK;
         else if (ovf_evt && !auto_en) ctrl_q[CB_RUN] <= 1'b0;
         if (wr_cnt)       cnt_q <= req_wdata;
         else if (wr_trig) cnt_q <= load_q;
         else if (tick)    cnt_q <= adv;
         if (wr_load)  load_q  <= req_wdata;
         if (wr_match) match_q <= req_wdata;
         if (wr_ifcfg) ifcfg_q <= req_wdata;
         if (wr_ien)   ien_q   <= req_wdata[NFLAG-1:0];
         if (wr_wen)   wen_q   <= req_wdata[NFLAG-1:0];
         if (cap_evt)  capt_q  <= cnt_q;
         stat_q <= (stat_q & ~clr_mask) | evt_vec;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          srst_q <= '0;
      else if (busy)                       srst_q <= srst_q - 1'b1;
      else if (wr_ifctl && req_wdata[1])   srst_q <= RCW'(RST_CYCLES);
   end

   // ---------------- write-pending slots ----------------
   assign pend_hit = {wr_match, wr_trig, wr_load, wr_cnt, wr_ctrl};

   for (genvar i = 0; i < NPEND; i++) begin : g_pend
      logic [PCW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            left_q <= '0;
         else if (busy)         left_q <= '0;
         else if (pend_hit[i])  left_q <= PCW'(PEND_CYCLES);
         else if (left_q != '0) left_q <= left_q - 1'b1;
      end
      assign pend_vec[i] = (left_q != '0);
   end

   // ---------------- read mux ----------------
   always_comb begin
      rsp_rdata = '0;
      if (req_valid && !req_write) begin
         case (req_addr)
            AW'(OFS_ID):    rsp_rdata = DW'(ID_VALUE);
            AW'(OFS_IFCFG): rsp_rdata = ifcfg_q;
            AW'(OFS_SYSST): rsp_rdata = {{(DW-1){1'b0}}, ~busy};
            AW'(OFS_ISTAT): rsp_rdata = DW'(stat_q);
            AW'(OFS_IEN):   rsp_rdata = DW'(ien_q);
            AW'(OFS_WEN):   rsp_rdata = DW'(wen_q);
            AW'(OFS_CTRL):  rsp_rdata = ctrl_q;
            AW'(OFS_CNT):   rsp_rdata = cnt_q;
            AW'(OFS_LOAD):  rsp_rdata = load_q;
            AW'(OFS_WPEND): rsp_rdata = DW'(pend_vec);
            AW'(OFS_MATCH): rsp_rdata = match_q;
            AW'(OFS_CAPT):  rsp_rdata = capt_q;
            default:        rsp_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk #(
   parameter int DW = 32
)(
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          wr,
   input logic          wr_stat,
   input logic          wr_ctrl,
   input logic          run_en,
   input logic          pre_en,
   input logic          auto_en,
   input logic [DW-1:0] cnt,
   input logic [2:0]    stat,
   input logic          irq,
   input logic          pend_ctrl
);
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !pre_en && !busy && !wr && !(&cnt)) |=> (cnt == $past(cnt) + 1'b1)); // R2

   AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !busy && !wr) |=> $stable(cnt)); // R2

   AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !pre_en && !busy && !wr && (&cnt) && !auto_en) |=> (cnt == '0 && !run_en)); // R4

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wr_stat && stat != 3'b000) |=> ((stat & $past(stat)) == $past(stat))); // R8

   AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !irq); // R11

   AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> pend_ctrl); // R12
endmodule

bind gp_timer gp_timer_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .wr        (wr),
   .wr_stat   (wr_stat),
   .wr_ctrl   (wr_ctrl),
   .run_en    (run_en),
   .pre_en    (pre_en),
   .auto_en   (auto_en),
   .cnt       (cnt_q),
   .stat      (stat_q),
   .irq       (irq),
   .pend_ctrl (pend_vec[0])
);

// File: tb/gp_timer_tb.sv
`timescale 1ns/1ps
module gp_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        v, w, cap;
   logic [7:0]  a;
   logic [31:0] d;
   logic [31:0] rdata;
   logic        ready, pwm, irq;
   int          checks = 0;
   int          errors = 0;
   bit          run_cmp = 0;

   always #2.5 clk = ~clk;

   gp_timer u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(v), .req_write(w), .req_addr(a),
      .req_wdata(d), .rsp_rdata(rdata), .rsp_ready(ready), .cap_in(cap),
      .pwm_out(pwm), .irq(irq)
   );

   // ---------------- behavioural reference ----------------
   bit [31:0] m_ctrl, m_cnt, m_load, m_match, m_capt, m_ifcfg;
   bit [2:0]  m_stat, m_ien, m_wen;
   int        m_srst, m_pre;
   bit        m_prev, m_pst, m_pls;
   int        m_pend[5];
   bit [7:0]  pend_addr[5] = '{8'h24, 8'h28, 8'h2C, 8'h30, 8'h38};

   task automatic model_clear();
      m_ctrl = 0; m_cnt = 0; m_load = 0; m_match = 0; m_capt = 0; m_ifcfg = 0;
      m_stat = 0; m_ien = 0; m_wen = 0;
      for (int i = 0; i < 5; i++) m_pend[i] = 0;
   endtask

   task automatic model_step();
      bit busy, wr, run, tick, atmax, ovf, mat, capev, fire;
      bit [31:0] nxt;
      bit [1:0] pt;
      int per;
      busy = (m_srst > 0);
      wr   = v && w && !busy;
      run  = m_ctrl[0] && !busy;
      per  = 2 ** (int'(m_ctrl[4:2]) + 1);
      tick = run && (!m_ctrl[5] || m_pre == per - 1);
      if (!run || !m_ctrl[5] || m_pre == per - 1) m_pre = 0; else m_pre++;
      atmax = (m_cnt == 32'hFFFF_FFFF);
      nxt   = atmax ? (m_ctrl[1] ? m_load : 32'h0) : m_cnt + 1;
      ovf   = tick && atmax;
      mat   = tick && m_ctrl[6] && (nxt == m_match);
      capev = (m_ctrl[8] && cap && !m_prev) || (m_ctrl[9] && !cap && m_prev);
      m_prev = cap;
      pt    = m_ctrl[11:10];
      fire  = (pt == 2'b01 && ovf) || (pt == 2'b10 && (ovf || mat));
      m_pls = fire;
      if (pt == 2'b00) m_pst = 0; else if (fire) m_pst = !m_pst;
      if (busy) begin
         model_clear();
         m_srst--;
         return;
      end
      for (int i = 0; i < 5; i++)
         if (wr && a == pend_addr[i]) m_pend[i] = 2; else if (m_pend[i] > 0) m_pend[i]--;
      if (wr && a == 8'h40 && d[1]) m_srst = 4;
      m_stat = (m_stat & ~((wr && a == 8'h18) ? d[2:0] : 3'b000)) | {capev, ovf, mat};
      if (capev) m_capt = m_cnt;
      if (wr && a == 8'h28) m_cnt = d;
      else if (wr && a == 8'h30) m_cnt = m_load;
      else if (tick) m_cnt = nxt;
      if (wr && a == 8'h24) m_ctrl = d & 32'h7FFF;
      else if (ovf && !m_ctrl[1]) m_ctrl[0] = 0;
      if (wr && a == 8'h2C) m_load  = d;
      if (wr && a == 8'h38) m_match = d;
      if (wr && a == 8'h10) m_ifcfg = d;
      if (wr && a == 8'h1C) m_ien   = d[2:0];
      if (wr && a == 8'h20) m_wen   = d[2:0];
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         model_clear(); m_srst = 0; m_pre = 0; m_prev = 0; m_pst = 0; m_pls = 0;
      end else model_step();
   end

   function automatic bit [31:0] exp_read(input bit [7:0] ad);
      bit [31:0] pv = 0;
      for (int i = 0; i < 5; i++) pv[i] = (m_pend[i] > 0);
      case (ad)
         8'h00: return 32'h0000_0021;
         8'h10: return m_ifcfg;
         8'h14: return {31'd0, m_srst == 0};
         8'h18: return {29'd0, m_stat};
         8'h1C: return {29'd0, m_ien};
         8'h20: return {29'd0, m_wen};
         8'h24: return m_ctrl;
         8'h28: return m_cnt;
         8'h2C: return m_load;
         8'h34: return pv;
         8'h38: return m_match;
         8'h3C: return m_capt;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit exp_pwm();
      bit idle = m_ctrl[7];
      if (m_ctrl[14]) return idle;
      return idle ^ (m_ctrl[12] ? m_pst : m_pls);
   endfunction

   // ---------------- checking ----------------
   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         check("R8 irq line", {31'd0, irq}, {31'd0, |(m_stat & m_ien)});
         check("R9 pwm pin", {31'd0, pwm}, {31'd0, exp_pwm()});
      end
   end

   task automatic wr32(input bit [7:0] ad, input bit [31:0] val);
      @(negedge clk); v = 1; w = 1; a = ad; d = val;
      @(posedge clk); #1 v = 0; w = 0;
   endtask

   task automatic rd32(input bit [7:0] ad, input string tag);
      @(negedge clk); v = 1; w = 0; a = ad; #1;
      check("R13 ready", {31'd0, ready}, 32'd1);
      check(tag, rdata, exp_read(ad));
      @(posedge clk); #1 v = 0;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      cycles(150000);
      errors++; checks++;
      $display("FAIL watchdog R1: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      v = 0; w = 0; a = 0; d = 0; cap = 0; rst_n = 0;
      cycles(3); #1 rst_n = 1; run_cmp = 1;

      // R1 reset state, R13 unmapped read
      rd32(8'h00, "R1 id");
      rd32(8'h24, "R1 ctrl");
      rd32(8'h28, "R1 counter");
      rd32(8'h14, "R1 reset done");
      rd32(8'h18, "R1 status");
      rd32(8'h44, "R13 unmapped");

      // R2 free count and hold
      wr32(8'h28, 100); wr32(8'h24, 1); cycles(10);
      rd32(8'h28, "R2 counting");
      wr32(8'h24, 0); cycles(3);
      rd32(8'h28, "R2 stopped"); cycles(4);
      rd32(8'h28, "R2 held");

      // R3 prescaler ratios
      for (int n = 0; n < 3; n++) begin
         wr32(8'h28, 0); wr32(8'h24, 32'h21 | (n << 2)); cycles(19 + n * 7);
         rd32(8'h28, "R3 prescaled");
      end
      wr32(8'h28, 0); wr32(8'h24, 32'h21 | (7 << 2)); cycles(600);
      rd32(8'h28, "R3 prescale max");
      wr32(8'h24, 0);

      // R5 trigger reload
      wr32(8'h2C, 32'h1234); wr32(8'h30, 32'hDEAD);
      rd32(8'h28, "R5 trigger reload");

      // R4 overflow with auto-reload, then one-shot
      wr32(8'h1C, 3'b010); wr32(8'h2C, 32'h40); wr32(8'h28, 32'hFFFF_FFFA);
      wr32(8'h24, 3); cycles(12);
      rd32(8'h28, "R4 auto reload");
      rd32(8'h18, "R4 overflow flag");
      wr32(8'h18, 3'b010);
      rd32(8'h18, "R8 clear overflow");
      wr32(8'h28, 32'hFFFF_FFFB); wr32(8'h24, 1); cycles(10);
      rd32(8'h24, "R4 one-shot stop");
      rd32(8'h28, "R4 wrap zero");

      // R6 match, R8 selective clear
      wr32(8'h18, 7); wr32(8'h1C, 3'b001); wr32(8'h38, 50); wr32(8'h28, 30);
      wr32(8'h24, 32'h41); cycles(25);
      rd32(8'h18, "R6 match flag");
      wr32(8'h18, 3'b100);
      rd32(8'h18, "R8 zero bits keep flag");
      wr32(8'h18, 3'b001);
      rd32(8'h18, "R8 w1c");

      // R7 capture edges
      wr32(8'h24, 0); wr32(8'h28, 500);
      for (int m = 0; m < 4; m++) begin
         wr32(8'h24, 1 | (m << 8));
         @(negedge clk); cap = 1;
         repeat (3) @(negedge clk); cap = 0;
         repeat (3) @(negedge clk);
         rd32(8'h3C, "R7 capture value");
         rd32(8'h18, "R7 capture flag");
         wr32(8'h18, 7);
      end

      // R9 PWM toggle on overflow, then pulse on overflow or match
      wr32(8'h2C, 32'hFFFF_FFF9); wr32(8'h28, 32'hFFFF_FFF9);
      wr32(8'h24, 32'h3 | (1 << 7) | (1 << 12) | (1 << 10)); cycles(40);
      wr32(8'h38, 32'hFFFF_FFFC);
      wr32(8'h24, 32'h3 | 32'h40 | (2 << 10)); cycles(40);
      wr32(8'h24, 32'h3 | 32'h40 | (1 << 12) | (2 << 10)); cycles(40);

      // R10 general-purpose output level
      wr32(8'h24, 32'h3 | 32'h40 | (1 << 7) | (1 << 14) | (1 << 12) | (1 << 10));
      cycles(20);
      @(negedge clk); #1 check("R10 gpo level", {31'd0, pwm}, 32'd1);

      // R12 write-pending window
      wr32(8'h24, 0);
      rd32(8'h34, "R12 pending first");
      rd32(8'h34, "R12 pending second");
      rd32(8'h34, "R12 pending clear");
      wr32(8'h38, 5);
      rd32(8'h34, "R12 match pending");

      // R11 soft reset
      wr32(8'h24, 3); wr32(8'h1C, 7); wr32(8'h10, 32'h18);
      wr32(8'h40, 32'h06);
      rd32(8'h14, "R11 busy");
      wr32(8'h2C, 32'h55);
      cycles(6);
      rd32(8'h14, "R11 done");
      rd32(8'h24, "R11 ctrl cleared");
      rd32(8'h1C, "R11 enable cleared");
      rd32(8'h10, "R11 config cleared");
      rd32(8'h2C, "R11 write ignored");

      cycles(2);
      finish_run();
   end
endmodule